// File: doc/BRIEF.md
# Quadrature Microstep Reference Generator

This block produces the two current-command words for a two-phase stepper driver running in microstep mode. It keeps an electrical angle counter that moves by one microstep on each step-up or step-down pulse. From that angle it derives a cosine word for phase A and a sine word for phase B. Both words are signed two's-complement values meant for a pair of DACs. At the peak they reach the full positive or full negative command. Because the two phases sit 90 electrical degrees apart, the resulting current vector turns by one microstep per pulse.

A full motor step is fixed at a quarter of the electrical cycle. The number of microsteps in each full step is a power of two, set by a parameter. The amplitudes come from an internal table that holds one quarter of a sine wave. The block folds that quarter into all four quadrants to get both outputs. It also reports which of the four full steps the angle is in. It raises a one-cycle strobe each time the output words change.

Top module: `ustep_ref_gen`

## Requirements
- R1: After reset, `cos_code` is +2047, `sin_code` is 0, `full_step` is 0 and `code_valid` is low.
- R2: A cycle in which `step_up` is high and `step_dn` is low advances the angle index k by one. The new output words appear after the next rising clock edge, and `code_valid` is high for exactly that one cycle.
- R3: A cycle in which `step_dn` is high and `step_up` is low moves k back by one. The timing and strobe are the same as in R2.
- R4: A cycle in which both pulses are high, or neither is high, leaves k and all outputs unchanged. In the following cycle `code_valid` is low.
- R5: Let N = 2^MSTEP_LOG2 microsteps per step (default 256) and theta = k·90°/N. Then `cos_code` = round(2047·cos theta) and `sin_code` = round(2047·sin theta). Both are 12-bit two's complement, and rounding is applied to the magnitude so that the code is symmetric about zero.
- R6: k counts modulo 4N. A step down from k=0 goes to k=4N−1, and a step up from k=4N−1 returns to k=0.
- R7: `full_step` equals floor(k/N), which ranges from 0 to 3. It changes by at most one, modulo 4, per update.
- R8: The signs follow the quadrant. In quadrant 0 both words are ≥0. In quadrant 1, cos ≤0 and sin ≥0. In quadrant 2 both are ≤0. In quadrant 3, cos ≥0 and sin ≤0. Neither word is ever −2048.
- R9: At each exact full-step position (k a multiple of N), one word is ±2047 and the other is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_up | input | 1 | Advance the angle by one microstep |
| step_dn | input | 1 | Retreat the angle by one microstep |
| cos_code | output | 12 | Signed phase A command word |
| sin_code | output | 12 | Signed phase B command word |
| full_step | output | 2 | Current full-step index within the electrical cycle |
| code_valid | output | 1 | One-cycle strobe when the output words update |

## Verification
The test drives runs of up pulses that cross quadrant boundaries. This separates errors in the folding of the table index from errors in the sign. It drives runs of down pulses, which expose a decrement or borrow that goes the wrong way. It inserts idle cycles and cycles where both pulses arrive together, which show whether the counter truly holds and the strobe stays low. A down pulse straight out of reset, followed by a complete walk of one electrical cycle, checks the wrap in both directions and every full-step position against amplitudes computed independently.

// File: rtl/ustep_ref_gen.sv
module ustep_ref_gen #(
  parameter int MSTEP_LOG2 = 8,
  parameter int DAC_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_up,
  input  logic                    step_dn,
  output logic signed [DAC_W-1:0] cos_code,
  output logic signed [DAC_W-1:0] sin_code,
  output logic [1:0]              full_step,
  output logic                    code_valid
);
  localparam int  N       = 1 << MSTEP_LOG2;
  localparam int  ANG_W   = MSTEP_LOG2 + 2;
  localparam int  MAG_W   = DAC_W - 1;
  localparam int  PEAK    = (1 << (DAC_W - 1)) - 1;
  localparam real HALF_PI = 1.5707963267948966;

  logic [MAG_W-1:0] qtab [N];
  for (genvar g = 0; g < N; g++) begin : g_tab
    localparam int V = $rtoi($floor(PEAK * $sin(HALF_PI * g / N) + 0.5));
    assign qtab[g] = MAG_W'(V);
  end

  logic [ANG_W-1:0] angle_q, angle_d;
  logic             move;
  logic [1:0]       quad;
  logic [MSTEP_LOG2:0] i_fwd, i_rev, sin_k, cos_k;
  logic [MAG_W-1:0]    sin_mag, cos_mag;
  logic signed [DAC_W-1:0] sin_d, cos_d;

  assign move    = step_up ^ step_dn;
  assign angle_d = step_up ? angle_q + ANG_W'(1) : angle_q - ANG_W'(1);
  assign quad    = angle_d[ANG_W-1 -: 2];
  assign i_fwd   = {1'b0, angle_d[MSTEP_LOG2-1:0]};
  assign i_rev   = (MSTEP_LOG2+1)'(N) - i_fwd;
  assign sin_k   = quad[0] ? i_rev : i_fwd;
  assign cos_k   = quad[0] ? i_fwd : i_rev;
  assign sin_mag = sin_k[MSTEP_LOG2] ? MAG_W'(PEAK) : qtab[sin_k[MSTEP_LOG2-1:0]];
  assign cos_mag = cos_k[MSTEP_LOG2] ? MAG_W'(PEAK) : qtab[cos_k[MSTEP_LOG2-1:0]];
  assign sin_d   = quad[1] ? -$signed({1'b0, sin_mag}) : $signed({1'b0, sin_mag});
  assign cos_d   = (quad[0] ^ quad[1]) ? -$signed({1'b0, cos_mag}) : $signed({1'b0, cos_mag});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q    <= '0;
      cos_code   <= DAC_W'(PEAK);
      sin_code   <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= move;
      if (move) begin
        angle_q  <= angle_d;
        cos_code <= cos_d;
        sin_code <= sin_d;
      end
    end
  end

  assign full_step = angle_q[ANG_W-1 -: 2];
endmodule

// File: rtl/ustep_ref_gen_chk.sv
module ustep_ref_gen_chk #(
  parameter int DAC_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_up,
  input logic                    step_dn,
  input logic signed [DAC_W-1:0] cos_code,
  input logic signed [DAC_W-1:0] sin_code,
  input logic [1:0]              full_step,
  input logic                    code_valid
);
  localparam logic [DAC_W-1:0] MOST_NEG = {1'b1, {(DAC_W-1){1'b0}}};

  // R2 / R3: one net pulse gives a strobe on the next cycle
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up ^ step_dn) |=> code_valid);

  // R4: cancelled or absent pulse holds everything
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up ^ step_dn) |=> (!code_valid && $stable(cos_code) &&
                              $stable(sin_code) && $stable(full_step)));

  // R7: full-step index moves by at most one per update
  p_step_adj_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up ^ step_dn) |=> (full_step == $past(full_step) ||
                             full_step == $past(full_step) + 2'd1 ||
                             full_step == $past(full_step) - 2'd1));

  // R8: quadrant signs
  p_sign_q0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_step == 2'd0 |-> (cos_code >= 0 && sin_code >= 0));
  p_sign_q1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_step == 2'd1 |-> (cos_code <= 0 && sin_code >= 0));
  p_sign_q2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_step == 2'd2 |-> (cos_code <= 0 && sin_code <= 0));
  p_sign_q3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_step == 2'd3 |-> (cos_code >= 0 && sin_code <= 0));

  // R8: symmetric range
  p_no_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_code != MOST_NEG) && (sin_code != MOST_NEG));
endmodule

bind ustep_ref_gen ustep_ref_gen_chk #(.DAC_W(DAC_W)) u_chk (.*);

// File: tb/ustep_ref_gen_bench.sv
module ustep_ref_gen_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  N          = 256;
  localparam int  CYC        = 4 * N;
  localparam real HALF_PI    = 1.5707963267948966;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_up = 1'b0;
  logic step_dn = 1'b0;
  logic signed [11:0] cos_code, sin_code;
  logic [1:0] full_step;
  logic code_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int k_model  = 0;
  bit done     = 0;

  ustep_ref_gen u_ustep_ref_gen (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .cos_code(cos_code), .sin_code(sin_code),
    .full_step(full_step), .code_valid(code_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {up, dn, repeat count}
  localparam logic [9:0] VEC [9] = '{
    {1'b1, 1'b0, 8'd5},
    {1'b0, 1'b1, 8'd3},
    {1'b1, 1'b0, 8'd255},
    {1'b1, 1'b1, 8'd2},
    {1'b0, 1'b0, 8'd2},
    {1'b1, 1'b0, 8'd200},
    {1'b0, 1'b1, 8'd250},
    {1'b1, 1'b0, 8'd60},
    {1'b0, 1'b1, 8'd100}
  };

  function automatic int ref_amp(int k, bit use_cos);
    real th = HALF_PI * k / N;
    real x  = use_cos ? $cos(th) : $sin(th);
    real m  = (x < 0.0) ? -x : x;
    int  r  = $rtoi($floor(2047.0 * m + 0.5));
    return (x < 0.0) ? -r : r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req, bit exp_valid);
    check({req, " cos (R5)"}, int'(cos_code), ref_amp(k_model, 1'b1));
    check({req, " sin (R5)"}, int'(sin_code), ref_amp(k_model, 1'b0));
    check({req, " full_step (R7)"}, int'(full_step), k_model / N);
    check({req, " strobe"}, int'(code_valid), int'(exp_valid));
  endtask

  task automatic pulse(bit u, bit d);
    @(negedge clk);
    step_up = u;
    step_dn = d;
    @(negedge clk);
    step_up = 1'b0;
    step_dn = 1'b0;
    if (u && !d) k_model = (k_model + 1) % CYC;
    if (d && !u) k_model = (k_model + CYC - 1) % CYC;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_up = 1'b0;
    step_dn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k_model = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 cos", int'(cos_code), 2047);
    check("R1 sin", int'(sin_code), 0);
    check("R1 full_step", int'(full_step), 0);
    check("R1 strobe", int'(code_valid), 0);

    // table walk: R2 up, R3 down, R4 cancel/idle
    for (int v = 0; v < 9; v++) begin
      for (int r = 0; r < int'(VEC[v][7:0]); r++) begin
        pulse(VEC[v][9], VEC[v][8]);
        if (VEC[v][9] ^ VEC[v][8])
          check_state(VEC[v][9] ? "R2 up" : "R3 down", 1'b1);
        else
          check_state("R4 hold", 1'b0);
      end
    end

    // R2: strobe lasts one cycle
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R2 strobe single cycle", int'(code_valid), 0);

    // R6: wrap down from zero and back up
    do_reset();
    pulse(1'b0, 1'b1);
    check("R6 wrap down full_step", int'(full_step), 3);
    check("R6 wrap down sin", int'(sin_code), -13);
    check("R6 wrap down cos", int'(cos_code), 2047);
    pulse(1'b1, 1'b0);
    check("R6 wrap up cos", int'(cos_code), 2047);
    check("R6 wrap up sin", int'(sin_code), 0);
    check("R6 wrap up full_step", int'(full_step), 0);

    // R4: simultaneous pulses at a quadrant edge leave state unchanged
    pulse(1'b1, 1'b1);
    check_state("R4 cancel at zero", 1'b0);

    // full cycle upward, R9 at full-step positions
    for (int i = 0; i < CYC; i++) begin
      pulse(1'b1, 1'b0);
      check_state("R2 sweep", 1'b1);
      if (k_model % N == 0) begin
        case (k_model / N)
          0: begin check("R9 k0 cos", int'(cos_code), 2047);  check("R9 k0 sin", int'(sin_code), 0); end
          1: begin check("R9 k1 cos", int'(cos_code), 0);     check("R9 k1 sin", int'(sin_code), 2047); end
          2: begin check("R9 k2 cos", int'(cos_code), -2047); check("R9 k2 sin", int'(sin_code), 0); end
          default: begin check("R9 k3 cos", int'(cos_code), 0); check("R9 k3 sin", int'(sin_code), -2047); end
        endcase
      end
    end
    check("R6 full cycle returns to zero", int'(full_step), 0);

    finish_run();
  end
endmodule